// File: doc/BRIEF.md
# Machine-Mode Status CSR Unit

This unit keeps the global interrupt-enable state of a 32-bit RISC-V hart that runs only in machine mode. It holds the live interrupt enable and its saved copy inside the machine status register. It updates both on trap entry and trap return, and drives the live enable out to the interrupt logic.

Software reaches the unit through a single-cycle CSR access port. The port carries an address, write data, a write mask and a two-bit operation (read, write, set, clear). The unit answers in the same cycle with combinational read data and an illegal-address flag. It also answers reads of the status-high register, which is all zero, and of the ISA-description register, whose extension bits come from build parameters. State changes take effect at the next rising clock edge.

Top module: `mcsr_status_unit`

## Requirements
- R1: Bits 12:11 of the status register (address 0x300) always read 2'b11, and no write, set or clear changes them.
- R2: Bit 3 of the status register is the live interrupt enable. Software can read and write it, and the output `irq_enable` always equals it.
- R3: When `trap_enter` is high at a clock edge, bit 7 takes the value bit 3 had before that edge, and bit 3 becomes 0.
- R4: When `trap_return` is high at a clock edge and `trap_enter` is low, bit 3 takes the value bit 7 had before that edge, and bit 7 becomes 1.
- R5: Bit 7 of the status register is readable and writable, and every status bit other than 3, 7, 11 and 12 reads as zero.
- R6: The status-high register (address 0x310) reads as 0x00000000 and accesses to it change no state.
- R7: The ISA register (address 0x301) reads with bits 31:30 = 2'b01, bit 12 = the multiply/divide parameter and bit 2 = the compressed parameter, all other bits zero. With the default parameters it reads 0x40001004. Writes to it are ignored and are not flagged illegal.
- R8: `csr_op` codes: 0 = read, 1 = write, 2 = set, 3 = clear. The bits that are affected are `csr_wmask` ANDed with the writable bits (3 and 7). A write loads `csr_wdata` into those bits, a set ORs it in, a clear removes the bits where `csr_wdata` is 1, and a read changes nothing. Access happens only when `csr_valid` is high.
- R9: A valid access to any address other than 0x300, 0x301 or 0x310 raises `csr_illegal` in the same cycle, reads zero and changes no state.
- R10: A trap entry in the same cycle as a status write takes priority and the write is discarded. A trap entry also wins over a simultaneous trap return. A trap return likewise discards a simultaneous status write.
- R11: An active-low asynchronous reset clears bits 3 and 7 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_valid | input | 1 | CSR access strobe |
| csr_addr | input | 12 | CSR address |
| csr_op | input | 2 | Operation: 0 read, 1 write, 2 set, 3 clear |
| csr_wdata | input | 32 | Write/set/clear operand |
| csr_wmask | input | 32 | Bits the access may touch |
| csr_rdata | output | 32 | Current value of the addressed CSR |
| csr_illegal | output | 1 | Unimplemented address accessed |
| trap_enter | input | 1 | Trap being taken this cycle |
| trap_return | input | 1 | Trap return this cycle |
| irq_enable | output | 1 | Global interrupt enable |

## Verification
On every cycle the assertions check the save and restore of the enable pair on trap entry and trap return. They also check that the previous-privilege field reads as machine mode, that the status-high register reads zero, that an illegal access leaves the state untouched, and that a plain status write lands in the live enable. Only the bench scenarios show the full register images and the exact ISA value. They also cover set and clear with partial masks, ignored writes to the ISA register, and the priority between a trap and a simultaneous software write. Reset in the middle of a run is likewise shown only there.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
    localparam int XLEN   = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] ADDR_STATUS    = 12'h300;
    localparam logic [ADDR_W-1:0] ADDR_ISA       = 12'h301;
    localparam logic [ADDR_W-1:0] ADDR_STATUS_HI = 12'h310;

    localparam int IE_BIT  = 3;
    localparam int PIE_BIT = 7;
    localparam int PP_LO   = 11;
    localparam int PP_HI   = 12;

    localparam int ISA_MXL_LO = 30;
    localparam int ISA_MUL    = 12;
    localparam int ISA_CMP    = 2;

    localparam logic [XLEN-1:0] STATUS_WRITABLE = (XLEN'(1) << IE_BIT) | (XLEN'(1) << PIE_BIT);

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } csr_op_e;

    typedef struct packed {
        logic pie;
        logic ie;
    } status_t;

    typedef struct packed {
        logic status;
        logic isa;
        logic status_hi;
    } sel_t;
endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
    import mcsr_pkg::*;
(
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    output sel_t              sel,
    output logic              illegal
);
    always_comb begin
        sel           = '0;
        sel.status    = (addr == ADDR_STATUS);
        sel.isa       = (addr == ADDR_ISA);
        sel.status_hi = (addr == ADDR_STATUS_HI);
        illegal       = valid && (sel == '0);
    end
endmodule

// File: rtl/mcsr_status_reg.sv
module mcsr_status_reg
    import mcsr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  csr_op_e         op,
    input  logic [XLEN-1:0] wdata,
    input  logic [XLEN-1:0] wmask,
    input  logic            trap_enter,
    input  logic            trap_return,
    output status_t         state_q
);
    status_t         state_d;
    logic [XLEN-1:0] eff_mask;
    logic [XLEN-1:0] cur_img;
    logic [XLEN-1:0] new_img;
    logic            unused_bits;

    always_comb begin
        eff_mask          = wmask & STATUS_WRITABLE;
        cur_img           = '0;
        cur_img[IE_BIT]   = state_q.ie;
        cur_img[PIE_BIT]  = state_q.pie;
        unique case (op)
            OP_WRITE: new_img = (cur_img & ~eff_mask) | (wdata & eff_mask);
            OP_SET:   new_img = cur_img | (wdata & eff_mask);
            OP_CLEAR: new_img = cur_img & ~(wdata & eff_mask);
            default:  new_img = cur_img;
        endcase

        state_d = state_q;
        if (trap_enter) begin
            state_d.pie = state_q.ie;
            state_d.ie  = 1'b0;
        end else if (trap_return) begin
            state_d.ie  = state_q.pie;
            state_d.pie = 1'b1;
        end else if (wr_en) begin
            state_d.ie  = new_img[IE_BIT];
            state_d.pie = new_img[PIE_BIT];
        end
    end

    assign unused_bits = ^(new_img & ~STATUS_WRITABLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/mcsr_read_mux.sv
module mcsr_read_mux
    import mcsr_pkg::*;
#(
    parameter bit HAS_MULDIV     = 1'b1,
    parameter bit HAS_COMPRESSED = 1'b1
) (
    input  sel_t            sel,
    input  logic            illegal,
    input  status_t         state,
    output logic [XLEN-1:0] rdata
);
    localparam logic [XLEN-1:0] ISA_VALUE =
        (XLEN'(1) << ISA_MXL_LO) |
        (XLEN'(HAS_MULDIV) << ISA_MUL) |
        (XLEN'(HAS_COMPRESSED) << ISA_CMP);

    logic [XLEN-1:0] status_img;

    always_comb begin
        status_img              = '0;
        status_img[PP_HI:PP_LO] = 2'b11;
        status_img[IE_BIT]      = state.ie;
        status_img[PIE_BIT]     = state.pie;

        rdata = '0;
        if (!illegal) begin
            if (sel.status)         rdata = status_img;
            else if (sel.isa)       rdata = ISA_VALUE;
            else if (sel.status_hi) rdata = '0;
        end
    end
endmodule

// File: rtl/mcsr_status_unit.sv
module mcsr_status_unit
    import mcsr_pkg::*;
#(
    parameter bit HAS_MULDIV     = 1'b1,
    parameter bit HAS_COMPRESSED = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_valid,
    input  logic [11:0] csr_addr,
    input  logic [1:0]  csr_op,
    input  logic [31:0] csr_wdata,
    input  logic [31:0] csr_wmask,
    output logic [31:0] csr_rdata,
    output logic        csr_illegal,
    input  logic        trap_enter,
    input  logic        trap_return,
    output logic        irq_enable
);
    sel_t    sel;
    status_t state_q;
    logic    ie_q;
    logic    pie_q;
    logic    status_wr;

    mcsr_decode u_decode (
        .valid   (csr_valid),
        .addr    (csr_addr),
        .sel     (sel),
        .illegal (csr_illegal)
    );

    assign status_wr = csr_valid && sel.status;

    mcsr_status_reg u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (status_wr),
        .op          (csr_op_e'(csr_op)),
        .wdata       (csr_wdata),
        .wmask       (csr_wmask),
        .trap_enter  (trap_enter),
        .trap_return (trap_return),
        .state_q     (state_q)
    );

    mcsr_read_mux #(
        .HAS_MULDIV     (HAS_MULDIV),
        .HAS_COMPRESSED (HAS_COMPRESSED)
    ) u_rmux (
        .sel     (sel),
        .illegal (csr_illegal),
        .state   (state_q),
        .rdata   (csr_rdata)
    );

    assign ie_q       = state_q.ie;
    assign pie_q      = state_q.pie;
    assign irq_enable = ie_q;
endmodule

// File: rtl/mcsr_status_unit_chk.sv
module mcsr_status_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        csr_valid,
    input logic [11:0] csr_addr,
    input logic [1:0]  csr_op,
    input logic [31:0] csr_wdata,
    input logic [31:0] csr_wmask,
    input logic [31:0] csr_rdata,
    input logic        csr_illegal,
    input logic        trap_enter,
    input logic        trap_return,
    input logic        ie_q,
    input logic        pie_q,
    input logic        irq_enable
);
    assert_pp_machine_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == 12'h300) |-> (csr_rdata[12:11] == 2'b11));

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && csr_addr == 12'h300 && csr_op == 2'b01 && csr_wmask[3]
         && !trap_enter && !trap_return) |=> (irq_enable == $past(csr_wdata[3])));

    assert_trap_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_enter |=> (!ie_q && pie_q == $past(ie_q)));

    assert_return_restores_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_return && !trap_enter) |=> (pie_q && ie_q == $past(pie_q)));

    assert_hi_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == 12'h310) |-> (csr_rdata == 32'h0));

    assert_illegal_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && csr_illegal && !trap_enter && !trap_return)
        |=> ($stable(ie_q) && $stable(pie_q)));
endmodule

bind mcsr_status_unit mcsr_status_unit_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_valid   (csr_valid),
    .csr_addr    (csr_addr),
    .csr_op      (csr_op),
    .csr_wdata   (csr_wdata),
    .csr_wmask   (csr_wmask),
    .csr_rdata   (csr_rdata),
    .csr_illegal (csr_illegal),
    .trap_enter  (trap_enter),
    .trap_return (trap_return),
    .ie_q        (ie_q),
    .pie_q       (pie_q),
    .irq_enable  (irq_enable)
);

// File: tb/mcsr_status_unit_tb_top.sv
`timescale 1ns/1ps
module mcsr_status_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_valid = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [1:0]  csr_op = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_wmask = '0;
    logic [31:0] csr_rdata;
    logic        csr_illegal;
    logic        trap_enter = 1'b0;
    logic        trap_return = 1'b0;
    logic        irq_enable;

    always #2 clk = ~clk;

    mcsr_status_unit dut_i (
        .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_addr(csr_addr),
        .csr_op(csr_op), .csr_wdata(csr_wdata), .csr_wmask(csr_wmask),
        .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
        .trap_enter(trap_enter), .trap_return(trap_return), .irq_enable(irq_enable)
    );

    typedef struct {
        logic [31:0] rdata;
        logic        illegal;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    logic m_ie = 0;
    logic m_pie = 0;

    function automatic logic [31:0] model_read(logic [11:0] a);
        if (a == 12'h300) return 32'h1800 | (32'(m_pie) << 7) | (32'(m_ie) << 3);
        if (a == 12'h301) return 32'h4000_1004;
        return 32'h0;
    endfunction

    task automatic op(input logic v, input logic [1:0] o, input logic [11:0] a,
                      input logic [31:0] wd, input logic [31:0] wm,
                      input logic te, input logic tr, input string tag);
        exp_t e;
        logic [31:0] img, m;
        @(negedge clk);
        csr_valid = v; csr_op = o; csr_addr = a; csr_wdata = wd; csr_wmask = wm;
        trap_enter = te; trap_return = tr;
        e.illegal = v && !(a == 12'h300 || a == 12'h301 || a == 12'h310);
        e.rdata   = e.illegal ? 32'h0 : model_read(a);
        e.irq     = m_ie;
        e.tag     = tag;
        exp_q.push_back(e);
        if (te) begin
            m_pie = m_ie; m_ie = 0;
        end else if (tr) begin
            m_ie = m_pie; m_pie = 1;
        end else if (v && a == 12'h300) begin
            img = (32'(m_pie) << 7) | (32'(m_ie) << 3);
            m = wm & 32'h88;
            case (o)
                2'b01: img = (img & ~m) | (wd & m);
                2'b10: img = img | (wd & m);
                2'b11: img = img & ~(wd & m);
                default: ;
            endcase
            m_ie = img[3]; m_pie = img[7];
        end
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        op(1, 2'b00, a, 32'h0, 32'h0, 0, 0, tag);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                checks++;
                if (csr_rdata !== e.rdata || csr_illegal !== e.illegal || irq_enable !== e.irq) begin
                    errors++;
                    $display("FAIL %s: actual rdata=%h illegal=%b irq=%b expected rdata=%h illegal=%b irq=%b",
                             e.tag, csr_rdata, csr_illegal, irq_enable, e.rdata, e.illegal, e.irq);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog (all requirements): actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(12'h300, "R11 reset state");
        rd(12'h300, "R1 pp field at reset");
        op(1, 2'b01, 12'h300, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, "R5 full write");
        rd(12'h300, "R5 only ie/pie/pp visible");
        op(1, 2'b01, 12'h300, 32'h0, 32'h1800, 0, 0, "R1 write pp zero");
        rd(12'h300, "R1 pp unchanged");
        op(0, 2'b00, 12'h300, 32'h0, 32'h0, 1, 0, "R3 trap entry");
        rd(12'h300, "R3 ie cleared pie saved");
        op(0, 2'b00, 12'h300, 32'h0, 32'h0, 0, 1, "R4 trap return");
        rd(12'h300, "R4 ie restored pie set");
        op(1, 2'b11, 12'h300, 32'h8, 32'hFFFF_FFFF, 0, 0, "R8 clear ie");
        rd(12'h300, "R2 ie cleared");
        op(0, 2'b00, 12'h300, 32'h0, 32'h0, 1, 0, "R3 trap with ie zero");
        rd(12'h300, "R3 both zero");
        op(0, 2'b00, 12'h300, 32'h0, 32'h0, 0, 1, "R4 return with pie zero");
        rd(12'h300, "R4 ie zero pie one");
        op(1, 2'b10, 12'h300, 32'h8, 32'h0, 0, 0, "R8 set with empty mask");
        rd(12'h300, "R8 empty mask no effect");
        op(1, 2'b10, 12'h300, 32'h88, 32'h8, 0, 0, "R8 set masked ie");
        rd(12'h300, "R2 ie set by set op");
        op(1, 2'b11, 12'h300, 32'h88, 32'h80, 0, 0, "R8 clear masked pie");
        rd(12'h300, "R8 pie cleared ie kept");
        op(1, 2'b00, 12'h300, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, "R8 read op inert");
        rd(12'h300, "R8 read op no change");
        op(1, 2'b01, 12'h300, 32'h88, 32'hFFFF_FFFF, 1, 0, "R10 trap vs write");
        rd(12'h300, "R10 trap won over write");
        op(1, 2'b01, 12'h300, 32'h8, 32'hFFFF_FFFF, 0, 1, "R10 return vs write");
        rd(12'h300, "R10 return won over write");
        op(0, 2'b00, 12'h300, 32'h0, 32'h0, 1, 1, "R10 trap vs return");
        rd(12'h300, "R10 trap won over return");
        rd(12'h301, "R7 isa value");
        op(1, 2'b01, 12'h301, 32'h0, 32'hFFFF_FFFF, 0, 0, "R7 isa write not illegal");
        rd(12'h301, "R7 isa unchanged");
        rd(12'h310, "R6 status hi zero");
        op(1, 2'b01, 12'h310, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, "R6 status hi write");
        rd(12'h310, "R6 status hi still zero");
        rd(12'h300, "R6 status unaffected");
        op(1, 2'b01, 12'h300, 32'h88, 32'h88, 0, 0, "R2 write both");
        op(1, 2'b11, 12'h305, 32'h88, 32'hFFFF_FFFF, 0, 0, "R9 illegal access");
        op(1, 2'b01, 12'h344, 32'h0, 32'hFFFF_FFFF, 0, 0, "R9 illegal write");
        rd(12'h300, "R9 state untouched");
        op(0, 2'b00, 12'h305, 32'h0, 32'h0, 0, 0, "R9 no flag without valid");
        @(negedge clk);
        csr_valid = 0; trap_enter = 0; trap_return = 0;
        rst_n = 1'b0; m_ie = 0; m_pie = 0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(12'h300, "R11 reset mid run");
        @(negedge clk);
        csr_valid = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule